// File: doc/BRIEF.md
# Half-Bridge Dead-Time Gate Controller

This block turns a single PWM command into two gate-enable outputs for the upper and lower switches of a half bridge. It is a synchronous design. The command and the two gate readback signals each pass through a two-flop synchronizer. Every width and delay is counted in clock cycles of the synchronized signals. An output may turn on only after two conditions hold: a programmable dead time has passed with both outputs low, and the readback of the opposite gate shows it is low. Short command pulses are sorted by width into bands, and each band gets its own response:

- A glitch is dropped.
- A short high pulse only makes the lower gate blink off.
- A medium high pulse turns the upper gate on and is stretched to a fixed minimum length.
- A short low dip only interrupts the upper gate.

An under-voltage flag forces both gates off. A sync-enable input keeps the lower gate off so that only the upper gate switches.

The controller is a Moore machine with seven states:

| State | Gates | Exits |
|---|---|---|
| IDLE | both off | to LO_DT when supply is good |
| LO_DT | both off, dead time before the lower gate | to LO_ON once the dead time has run and the upper readback is low |
| LO_ON | lower gate on (if enabled) | to LO_OFF on the POS_IGN-th high cycle |
| LO_OFF | both off, pulse being qualified | to LO_DT if the command drops before POS_LO cycles; to HI_DT on the POS_LO-th high cycle |
| HI_DT | both off, dead time before the upper gate | to HI_ON once the dead time has run and the lower readback is low |
| HI_ON | upper gate on | to HI_OFF on the NEG_IGN-th low cycle of the stretched command |
| HI_OFF | both off, dip being qualified | to HI_DT if the command returns; to LO_DT on the NEG_LO-th low cycle |

A low supply flag sends any state to IDLE. A pulse that begins while LO_DT is still running is counted from the cycle LO_ON is entered. A command that rises again out of HI_OFF is not stretched a second time.

Top module: `hb_gate_ctrl`

## Requirements
- R1: `hg` rises only after `lg` has been low for at least DEAD_CYC consecutive cycles. `lg` rises only after `hg` has been low for at least DEAD_CYC consecutive cycles.
- R2: `hg` and `lg` are never high in the same cycle.
- R3: An output turns on only if the synchronized readback of the opposite gate was low in the cycle before. If `lg_fb` stays high, `hg` never turns on. Once `lg_fb` is released, `hg` turns on.
- R4: In the cycle after `uvlo_ok` is sampled low, both outputs are low, and they stay low while it remains low. When it returns high with `in_cmd` low, `lg` turns on again.
- R5: While `sync_en` is low, `lg` is low, and `hg` still follows qualified pulses.
- R6: A high pulse on `in_cmd` shorter than POS_IGN cycles changes neither output.
- R7: A high pulse of POS_IGN to POS_LO-1 cycles turns `lg` off and then on again, and `hg` stays low.
- R8: A high pulse of at least POS_LO cycles turns `hg` on. The on-time of `hg` is the same for every width up to POS_STR cycles. Above POS_STR, it grows by one cycle per extra cycle of width.
- R9: While `hg` is on, a low dip on `in_cmd` shorter than NEG_IGN cycles leaves `hg` high.
- R10: A low dip of NEG_IGN to NEG_LO-1 cycles turns `hg` off and back on, and `lg` stays low. A dip of NEG_LO cycles or more turns `lg` on.
- R11: While reset is high both outputs are low. In the first cycle after reset `lg` is still low. With supply good and `in_cmd` low, `lg` later turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_cmd | input | 1 | PWM command, high requests the upper gate |
| sync_en | input | 1 | Low keeps the lower gate off |
| uvlo_ok | input | 1 | Supply-good flag, low forces both gates off |
| hg_fb | input | 1 | Readback of the upper gate drive |
| lg_fb | input | 1 | Readback of the lower gate drive |
| hg | output | 1 | Upper gate enable |
| lg | output | 1 | Lower gate enable |

## Verification
The properties assume that each readback input follows its own output within a few cycles. They also assume that `uvlo_ok` and `sync_en` are already synchronous to `clk`. No property forces either of these, so the interlock property only relates a turn-on to the readback value seen one cycle earlier. The stimulus meets these assumptions in three ways:

- It models both readbacks as the outputs delayed by two clock edges.
- It forces the lower readback high only in the test that checks the interlock hold-off.
- It changes the flags a fixed time after the clock edge, never at the edge.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LO_DT,
        ST_LO_ON,
        ST_LO_OFF,
        ST_HI_DT,
        ST_HI_ON,
        ST_HI_OFF
    } hbg_state_e;

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= '0;
            end
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/hbg_sat_cnt.sv
module hbg_sat_cnt #(
    parameter int  MAX_VAL = 4,
    localparam int W       = $clog2(MAX_VAL + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] TOP = W'(MAX_VAL);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && (cnt != TOP)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/hbg_fsm.sv
module hbg_fsm
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC    = 4,
    parameter int POS_IGN_CYC = 2,
    parameter int POS_LO_CYC  = 9,
    parameter int POS_STR_CYC = 32,
    parameter int NEG_IGN_CYC = 1,
    parameter int NEG_LO_CYC  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic in_s,
    input  logic hg_fb_s,
    input  logic lg_fb_s,
    input  logic sync_en,
    input  logic uvlo_ok,
    output logic hg,
    output logic lg
);

    localparam int DW = $clog2(DEAD_CYC + 1);
    localparam int PW = $clog2(POS_STR_CYC + 1);
    localparam int NW = $clog2(NEG_LO_CYC + 1);

    localparam logic [DW-1:0] DT_LAST = DW'(DEAD_CYC - 1);
    localparam logic [PW-1:0] PC_IGN  = PW'(POS_IGN_CYC - 1);
    localparam logic [PW-1:0] PC_LO   = PW'(POS_LO_CYC - 1);
    localparam logic [PW-1:0] PC_STR  = PW'(POS_STR_CYC);
    localparam logic [NW-1:0] NC_IGN  = NW'(NEG_IGN_CYC - 1);
    localparam logic [NW-1:0] NC_LO   = NW'(NEG_LO_CYC - 1);

    hbg_state_e st_q;
    hbg_state_e st_nx;

    logic [DW-1:0] dt_cnt;
    logic [PW-1:0] pc_cnt;
    logic [NW-1:0] nc_cnt;

    logic dt_clr, dt_inc, dt_done;
    logic pc_clr, pc_inc;
    logic nc_clr, nc_inc;
    logic in_dt, hi_side, eff;

    // dead-time counter: runs only while in a dead-time state
    hbg_sat_cnt #(.MAX_VAL(DEAD_CYC)) u_dt_cnt (
        .clk (clk),
        .rst (rst),
        .clr (dt_clr),
        .inc (dt_inc),
        .cnt (dt_cnt)
    );

    // cycles since the command rose, saturating at the stretch length
    hbg_sat_cnt #(.MAX_VAL(POS_STR_CYC)) u_pc_cnt (
        .clk (clk),
        .rst (rst),
        .clr (pc_clr),
        .inc (pc_inc),
        .cnt (pc_cnt)
    );

    // consecutive low cycles of the stretched command
    hbg_sat_cnt #(.MAX_VAL(NEG_LO_CYC)) u_nc_cnt (
        .clk (clk),
        .rst (rst),
        .clr (nc_clr),
        .inc (nc_inc),
        .cnt (nc_cnt)
    );

    always_comb begin
        in_dt   = (st_q == ST_LO_DT) || (st_q == ST_HI_DT);
        hi_side = (st_q == ST_HI_DT) || (st_q == ST_HI_ON) || (st_q == ST_HI_OFF);
        dt_done = (dt_cnt >= DT_LAST);
        eff     = in_s || (pc_cnt < PC_STR);
    end

    // next-state logic
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: begin
                st_nx = ST_LO_DT;
            end
            ST_LO_DT: begin
                if (dt_done && !hg_fb_s) begin
                    st_nx = ST_LO_ON;
                end
            end
            ST_LO_ON: begin
                if (in_s && (pc_cnt == PC_IGN)) begin
                    st_nx = ST_LO_OFF;
                end
            end
            ST_LO_OFF: begin
                if (!in_s) begin
                    st_nx = ST_LO_DT;
                end else if (pc_cnt == PC_LO) begin
                    st_nx = ST_HI_DT;
                end
            end
            ST_HI_DT: begin
                if (dt_done && !lg_fb_s) begin
                    st_nx = ST_HI_ON;
                end
            end
            ST_HI_ON: begin
                if (!eff && (nc_cnt == NC_IGN)) begin
                    st_nx = ST_HI_OFF;
                end
            end
            ST_HI_OFF: begin
                if (eff) begin
                    st_nx = ST_HI_DT;
                end else if (nc_cnt == NC_LO) begin
                    st_nx = ST_LO_DT;
                end
            end
            default: begin
                st_nx = ST_IDLE;
            end
        endcase
        if (!uvlo_ok) begin
            st_nx = ST_IDLE;
        end
    end

    // counter controls
    always_comb begin
        dt_inc = in_dt;
        dt_clr = !in_dt || (st_nx != st_q);
        pc_inc = hi_side || in_s;
        pc_clr = (st_q == ST_IDLE) || (st_q == ST_LO_DT)
               || ((st_q == ST_LO_ON) && !in_s) || !uvlo_ok;
        nc_inc = !eff;
        nc_clr = !hi_side || (st_q == ST_HI_DT) || ((st_q == ST_HI_ON) && eff);
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    // outputs
    always_comb begin
        hg = (st_q == ST_HI_ON);
        lg = (st_q == ST_LO_ON) && sync_en;
    end

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl #(
    parameter int DEAD_CYC    = 4,
    parameter int POS_IGN_CYC = 2,
    parameter int POS_LO_CYC  = 9,
    parameter int POS_STR_CYC = 32,
    parameter int NEG_IGN_CYC = 1,
    parameter int NEG_LO_CYC  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic in_cmd,
    input  logic sync_en,
    input  logic uvlo_ok,
    input  logic hg_fb,
    input  logic lg_fb,
    output logic hg,
    output logic lg
);

    logic [2:0] sync_q;
    logic       in_s;
    logic       hg_fb_s;
    logic       lg_fb_s;

    hbg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({in_cmd, hg_fb, lg_fb}),
        .q   (sync_q)
    );

    assign in_s    = sync_q[2];
    assign hg_fb_s = sync_q[1];
    assign lg_fb_s = sync_q[0];

    hbg_fsm #(
        .DEAD_CYC    (DEAD_CYC),
        .POS_IGN_CYC (POS_IGN_CYC),
        .POS_LO_CYC  (POS_LO_CYC),
        .POS_STR_CYC (POS_STR_CYC),
        .NEG_IGN_CYC (NEG_IGN_CYC),
        .NEG_LO_CYC  (NEG_LO_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .in_s    (in_s),
        .hg_fb_s (hg_fb_s),
        .lg_fb_s (lg_fb_s),
        .sync_en (sync_en),
        .uvlo_ok (uvlo_ok),
        .hg      (hg),
        .lg      (lg)
    );

endmodule

// File: rtl/hbg_checker.sv
module hbg_checker #(
    parameter int DEAD_CYC = 4
) (
    input logic clk,
    input logic rst,
    input logic hg,
    input logic lg,
    input logic uvlo_ok,
    input logic sync_en,
    input logic hg_fb_s,
    input logic lg_fb_s
);

    localparam int RW = $clog2(DEAD_CYC + 1);
    localparam logic [RW-1:0] RUN_TOP = RW'(DEAD_CYC);

    logic [RW-1:0] hg_off_run;
    logic [RW-1:0] lg_off_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hg_off_run <= '0;
            lg_off_run <= '0;
        end else begin
            hg_off_run <= hg ? '0 : ((hg_off_run == RUN_TOP) ? hg_off_run : hg_off_run + 1'b1);
            lg_off_run <= lg ? '0 : ((lg_off_run == RUN_TOP) ? lg_off_run : lg_off_run + 1'b1);
        end
    end

    assert_dead_hg_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(hg) |-> (lg_off_run >= RUN_TOP));

    assert_dead_lg_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(lg) |-> (hg_off_run >= RUN_TOP));

    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
        !(hg && lg));

    assert_fb_hg_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(hg) |-> $past(!lg_fb_s));

    assert_fb_lg_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(lg) |-> $past(!hg_fb_s));

    assert_uvlo_off_R4: assert property (@(posedge clk) disable iff (rst)
        !uvlo_ok |=> (!hg && !lg));

    assert_sync_off_R5: assert property (@(posedge clk) disable iff (rst)
        !sync_en |-> !lg);

endmodule

bind hb_gate_ctrl hbg_checker #(.DEAD_CYC(DEAD_CYC)) u_hbg_chk (
    .clk     (clk),
    .rst     (rst),
    .hg      (hg),
    .lg      (lg),
    .uvlo_ok (uvlo_ok),
    .sync_en (sync_en),
    .hg_fb_s (hg_fb_s),
    .lg_fb_s (lg_fb_s)
);

// File: tb/hb_gate_ctrl_bench.sv
module hb_gate_ctrl_bench;

    localparam int DEAD   = 4;
    localparam int P_IGN  = 2;
    localparam int P_LO   = 9;
    localparam int P_STR  = 32;
    localparam int N_IGN  = 2;
    localparam int N_LO   = 8;
    localparam int NPOS   = 11;
    localparam int NNEG   = 5;

    // {high width, expect lg dip, expect hg on}
    localparam int POS_TBL [NPOS][3] = '{
        '{1, 0, 0}, '{2, 1, 0}, '{5, 1, 0}, '{8, 1, 0}, '{9, 1, 1}, '{12, 1, 1},
        '{20, 1, 1}, '{31, 1, 1}, '{32, 1, 1}, '{33, 1, 1}, '{40, 1, 1}
    };
    // {low width, expect hg dip, expect lg on}
    localparam int NEG_TBL [NNEG][3] = '{
        '{1, 0, 0}, '{2, 1, 0}, '{5, 1, 0}, '{7, 1, 0}, '{8, 1, 1}
    };

    logic clk = 1'b0;
    logic rst, in_cmd, sync_en, uvlo_ok, stuck_lg;
    logic hg, lg, hg_fb, lg_fb;
    logic hd1 = 1'b0, hd2 = 1'b0, ld1 = 1'b0, ld2 = 1'b0;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    int ov_cnt = 0, gap_viol = 0, hg_rise = 0, lg_rise = 0;
    int hg_cyc = 0, lg_cyc = 0, hg_low = 0, lg_low = 0;
    int hg_low_run = 0, lg_low_run = 0;
    logic hg_prev = 1'b0, lg_prev = 1'b0;
    int hgw [NPOS];

    always #4 clk = ~clk;

    hb_gate_ctrl #(
        .DEAD_CYC(DEAD), .POS_IGN_CYC(P_IGN), .POS_LO_CYC(P_LO),
        .POS_STR_CYC(P_STR), .NEG_IGN_CYC(N_IGN), .NEG_LO_CYC(N_LO)
    ) u_hb_gate_ctrl (
        .clk(clk), .rst(rst), .in_cmd(in_cmd), .sync_en(sync_en), .uvlo_ok(uvlo_ok),
        .hg_fb(hg_fb), .lg_fb(lg_fb), .hg(hg), .lg(lg)
    );

    // feedback model: outputs delayed by two edges
    always @(posedge clk) begin
        hd1 <= hg; hd2 <= hd1;
        ld1 <= lg; ld2 <= ld1;
    end
    assign hg_fb = hd2;
    assign lg_fb = ld2 | stuck_lg;

    always @(negedge clk) begin
        if (hg && lg) ov_cnt++;
        if (hg && !hg_prev) begin
            hg_rise++;
            if (lg_low_run < DEAD) gap_viol++;
        end
        if (lg && !lg_prev) begin
            lg_rise++;
            if (hg_low_run < DEAD) gap_viol++;
        end
        if (hg) hg_cyc++; else hg_low++;
        if (lg) lg_cyc++; else lg_low++;
        hg_low_run = hg ? 0 : hg_low_run + 1;
        lg_low_run = lg ? 0 : lg_low_run + 1;
        hg_prev = hg;
        lg_prev = lg;
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold(logic v, int n);
        in_cmd = v;
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_cmd = 1'b0; sync_en = 1'b1; uvlo_ok = 1'b1; stuck_lg = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 hg in reset", int'(hg), 0);
        chk("R11 lg in reset", int'(lg), 0);
        @(posedge clk); #2;
        rst = 1'b0;
        @(negedge clk);
        chk("R11 lg first cycle", int'(lg), 0);
        @(posedge clk); #2;
        hold(1'b0, 30);
        chk("R11 lg after reset", int'(lg), 1);

        // positive pulse bands R6 R7 R8
        for (int i = 0; i < NPOS; i++) begin
            int w, s_ll, s_hr, s_hc;
            w = POS_TBL[i][0];
            s_ll = lg_low; s_hr = hg_rise; s_hc = hg_cyc;
            hold(1'b1, w);
            hold(1'b0, 90);
            chk((w < P_IGN) ? "R6 lg dip" : "R7 lg dip", (lg_low > s_ll) ? 1 : 0, POS_TBL[i][1]);
            chk((w < P_LO) ? "R7 hg stays low" : "R8 hg on", (hg_rise > s_hr) ? 1 : 0, POS_TBL[i][2]);
            chk("R7 lg back on", int'(lg), 1);
            hgw[i] = hg_cyc - s_hc;
        end
        begin
            int refw;
            refw = hgw[8];
            for (int i = 0; i < NPOS; i++) begin
                if (POS_TBL[i][0] >= P_LO && POS_TBL[i][0] < P_STR)
                    chk("R8 stretched width", hgw[i], refw);
                else if (POS_TBL[i][0] > P_STR)
                    chk("R8 long width", hgw[i], refw + POS_TBL[i][0] - P_STR);
            end
        end

        // negative dip bands R9 R10
        for (int i = 0; i < NNEG; i++) begin
            int w, s_hl, s_lc;
            w = NEG_TBL[i][0];
            hold(1'b1, 60);
            s_hl = hg_low; s_lc = lg_cyc;
            hold(1'b0, w);
            hold(1'b1, 40);
            chk((w < N_IGN) ? "R9 hg dip" : "R10 hg dip", (hg_low > s_hl) ? 1 : 0, NEG_TBL[i][1]);
            chk("R10 lg on", (lg_cyc > s_lc) ? 1 : 0, NEG_TBL[i][2]);
            chk("R10 hg on at end", int'(hg), 1);
            hold(1'b0, 90);
        end

        // supply lockout R4
        hold(1'b1, 60);
        chk("R4 hg before lockout", int'(hg), 1);
        uvlo_ok = 1'b0;
        @(posedge clk); #2;
        begin
            int s_hc, s_lc;
            s_hc = hg_cyc; s_lc = lg_cyc;
            hold(1'b1, 15);
            hold(1'b0, 15);
            chk("R4 hg held low", hg_cyc - s_hc, 0);
            chk("R4 lg held low", lg_cyc - s_lc, 0);
        end
        uvlo_ok = 1'b1;
        hold(1'b0, 30);
        chk("R4 lg recovers", int'(lg), 1);

        // low side disabled R5
        sync_en = 1'b0;
        @(negedge clk);
        chk("R5 lg off at once", int'(lg), 0);
        @(posedge clk); #2;
        begin
            int s_lc, s_hr;
            s_lc = lg_cyc; s_hr = hg_rise;
            hold(1'b1, 40);
            hold(1'b0, 60);
            chk("R5 lg never on", lg_cyc - s_lc, 0);
            chk("R5 hg switches", (hg_rise > s_hr) ? 1 : 0, 1);
        end
        sync_en = 1'b1;
        hold(1'b0, 5);
        chk("R5 lg restored", int'(lg), 1);

        // stuck readback R3
        stuck_lg = 1'b1;
        begin
            int s_hr;
            s_hr = hg_rise;
            hold(1'b1, 60);
            chk("R3 hg held off", hg_rise - s_hr, 0);
            chk("R3 lg off", int'(lg), 0);
        end
        stuck_lg = 1'b0;
        hold(1'b1, 20);
        chk("R3 hg after release", int'(hg), 1);
        hold(1'b0, 90);

        chk("R2 overlap cycles", ov_cnt, 0);
        chk("R1 dead-time violations", gap_viol, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule